// File: doc/BRIEF.md
# Program Counter Next-Address Unit

This block keeps the instruction address of a 32-bit RISC core and chooses the address to fetch on the next cycle. Every cycle the core presents four kinds of control: a step enable, a taken-branch flag with a signed 16-bit offset counted in instructions, a direct-jump flag with a 26-bit target field, and an indirect-jump flag with a full 32-bit register value. The unit selects one source by fixed priority. It updates the held address on the following clock edge.

A branch is resolved relative to the address of the next sequential instruction. A direct jump keeps the upper region bits of that address and places the target field below them. An indirect jump can reach any word-aligned address. An indirect target that is not word aligned raises an error flag in the same cycle, and the address does not move in that cycle. A synchronous reset loads a start address that is set by a parameter.

Top module: `pc_next_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, `pc` takes the value START_ADDR (default 0x00400000) on that edge, whatever the other inputs are.
- R2: When `step_en` is low, `pc` keeps its value, even if jump or branch controls are asserted.
- R3: When `step_en` is high and no control flag is set, the next `pc` is `pc + 4`.
- R4: When `br_take` is the highest-priority control set, the next `pc` is `pc + 4 + (sign-extended br_ofs × 4)`. This holds at the extremes 0x7FFF and 0x8000, and for negative offsets.
- R5: When `jmp_dir` is the highest-priority control set, the next `pc` is built from bits [31:28] of `pc + 4`, then `jmp_field` in bits [27:2], then 00 in bits [1:0]. Because the region comes from `pc + 4`, a jump from the last word of a 256 MB region lands in the next region.
- R6: When `jmp_reg` is set and `reg_val[1:0]` is 00, the next `pc` equals `reg_val` in all 32 bits.
- R7: The priority order is `jmp_reg`, then `jmp_dir`, then `br_take`, then the sequential increment.
- R8: When `step_en` and `jmp_reg` are both high and `reg_val[1:0]` is not 00, `misalign` is high in that same cycle (it is combinational) and `pc` does not change at the next edge. No lower-priority control takes effect in that case. In every other case `misalign` is low, whatever the value of `reg_val`.
- R9: Bits [1:0] of `pc` are always 00 outside reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| step_en | input | 1 | Allows the address to advance this cycle |
| br_take | input | 1 | Conditional branch taken |
| br_ofs | input | 16 | Signed branch offset, in instructions |
| jmp_dir | input | 1 | Direct jump request |
| jmp_field | input | 26 | Direct jump target field |
| jmp_reg | input | 1 | Indirect (register) jump request |
| reg_val | input | 32 | Indirect jump target |
| pc | output | 32 | Current instruction address |
| misalign | output | 1 | Indirect target not word aligned |

## Verification
The bench drives branch offsets at both ends of the signed range and the all-ones offset. A design that forgets to sign-extend, or that shifts the offset by the wrong amount, goes to a far-off address. It jumps directly from 0x0FFFFFFC. A unit that takes the region bits from the current address instead of from the next sequential address stays in region 0 instead of going to region 1. It asserts several controls together to catch a wrong priority order. It also gives misaligned indirect targets with a branch asserted alongside: a unit that falls through to the branch, or that updates anyway, shows a moved address. It checks that a bad `reg_val` with `jmp_reg` low, or with `step_en` low, leaves the error flag clear.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
   typedef enum logic [1:0] {
      SRC_SEQ    = 2'd0,
      SRC_BRANCH = 2'd1,
      SRC_JUMP   = 2'd2,
      SRC_REG    = 2'd3
   } pcu_src_e;
endpackage

// File: rtl/pcu_select.sv
module pcu_select
   import pcu_pkg::*;
(
   input  logic     br_take,
   input  logic     jmp_dir,
   input  logic     jmp_reg,
   output pcu_src_e src
);
   // fixed priority: register jump > direct jump > branch > sequential
   always_comb begin
      if (jmp_reg)      src = SRC_REG;
      else if (jmp_dir) src = SRC_JUMP;
      else if (br_take) src = SRC_BRANCH;
      else              src = SRC_SEQ;
   end
endmodule

// File: rtl/pcu_target.sv
module pcu_target
   import pcu_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int OFS_W      = 16,
   parameter int JTGT_W     = 26,
   parameter int ALIGN_BITS = 2
) (
   input  logic [ADDR_W-1:0] pc,
   input  logic [OFS_W-1:0]  br_ofs,
   input  logic [JTGT_W-1:0] jmp_field,
   input  logic [ADDR_W-1:0] reg_val,
   input  pcu_src_e          src,
   output logic [ADDR_W-1:0] next_addr,
   output logic              reg_unaligned
);
   localparam int STEP     = 1 << ALIGN_BITS;
   localparam int EXT_W    = ADDR_W - OFS_W - ALIGN_BITS;
   localparam int REGION_W = ADDR_W - JTGT_W - ALIGN_BITS;

   logic [ADDR_W-1:0] seq_addr;
   logic [ADDR_W-1:0] br_disp;
   logic [ADDR_W-1:0] br_addr;
   logic [ADDR_W-1:0] jmp_addr;

   assign seq_addr = pc + ADDR_W'(STEP);
   assign br_disp  = {{EXT_W{br_ofs[OFS_W-1]}}, br_ofs, {ALIGN_BITS{1'b0}}};
   assign br_addr  = seq_addr + br_disp;

   generate
      if (REGION_W > 0) begin : g_region
         assign jmp_addr = {seq_addr[ADDR_W-1 -: REGION_W], jmp_field, {ALIGN_BITS{1'b0}}};
      end else begin : g_flat
         assign jmp_addr = {jmp_field, {ALIGN_BITS{1'b0}}};
      end
   endgenerate

   assign reg_unaligned = |reg_val[ALIGN_BITS-1:0];

   always_comb begin
      unique case (src)
         SRC_REG:    next_addr = reg_val;
         SRC_JUMP:   next_addr = jmp_addr;
         SRC_BRANCH: next_addr = br_addr;
         default:    next_addr = seq_addr;
      endcase
   end
endmodule

// File: rtl/pcu_reg.sv
module pcu_reg #(
   parameter int              ADDR_W     = 32,
   parameter logic [ADDR_W-1:0] START_ADDR = 32'h0040_0000
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [ADDR_W-1:0] d,
   output logic [ADDR_W-1:0] q
);
   always_ff @(posedge clk) begin
      if (rst)       q <= START_ADDR;
      else if (load) q <= d;
   end
endmodule

// File: rtl/pc_next_unit.sv
module pc_next_unit
   import pcu_pkg::*;
#(
   parameter int                ADDR_W     = 32,
   parameter int                OFS_W      = 16,
   parameter int                JTGT_W     = 26,
   parameter int                ALIGN_BITS = 2,
   parameter logic [ADDR_W-1:0] START_ADDR = 32'h0040_0000
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              step_en,
   input  logic              br_take,
   input  logic [OFS_W-1:0]  br_ofs,
   input  logic              jmp_dir,
   input  logic [JTGT_W-1:0] jmp_field,
   input  logic              jmp_reg,
   input  logic [ADDR_W-1:0] reg_val,
   output logic [ADDR_W-1:0] pc,
   output logic              misalign
);
   generate
      if (ALIGN_BITS < 1) begin : g_bad_align
         $error("ALIGN_BITS must be at least 1");
      end
      if (ADDR_W < OFS_W + ALIGN_BITS) begin : g_bad_ofs
         $error("ADDR_W too small for the branch offset");
      end
      if (ADDR_W < JTGT_W + ALIGN_BITS) begin : g_bad_jtgt
         $error("ADDR_W too small for the jump field");
      end
      if (START_ADDR[ALIGN_BITS-1:0] != '0) begin : g_bad_start
         $error("START_ADDR must be aligned");
      end
   endgenerate

   pcu_src_e          src;
   logic [ADDR_W-1:0] next_addr;
   logic              reg_unaligned;
   logic              fault;

   pcu_select u_sel (
      .br_take (br_take),
      .jmp_dir (jmp_dir),
      .jmp_reg (jmp_reg),
      .src     (src)
   );

   pcu_target #(
      .ADDR_W     (ADDR_W),
      .OFS_W      (OFS_W),
      .JTGT_W     (JTGT_W),
      .ALIGN_BITS (ALIGN_BITS)
   ) u_tgt (
      .pc            (pc),
      .br_ofs        (br_ofs),
      .jmp_field     (jmp_field),
      .reg_val       (reg_val),
      .src           (src),
      .next_addr     (next_addr),
      .reg_unaligned (reg_unaligned)
   );

   assign fault    = step_en && (src == SRC_REG) && reg_unaligned;
   assign misalign = fault;

   pcu_reg #(
      .ADDR_W     (ADDR_W),
      .START_ADDR (START_ADDR)
   ) u_reg (
      .clk  (clk),
      .rst  (rst),
      .load (step_en && !fault),
      .d    (next_addr),
      .q    (pc)
   );
endmodule

// File: rtl/pcu_checker.sv
module pcu_checker #(
   parameter int ADDR_W     = 32,
   parameter int ALIGN_BITS = 2
) (
   input logic              clk,
   input logic              rst,
   input logic              step_en,
   input logic              br_take,
   input logic              jmp_dir,
   input logic              jmp_reg,
   input logic [ADDR_W-1:0] reg_val,
   input logic [ADDR_W-1:0] pc,
   input logic              misalign
);
   localparam int STEP = 1 << ALIGN_BITS;

   a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
      !step_en |=> $stable(pc));

   a_r3_sequential: assert property (@(posedge clk) disable iff (rst)
      step_en && !jmp_reg && !jmp_dir && !br_take |=> pc == $past(pc) + ADDR_W'(STEP));

   a_r6_reg_target: assert property (@(posedge clk) disable iff (rst)
      step_en && jmp_reg && reg_val[ALIGN_BITS-1:0] == '0 |=> pc == $past(reg_val));

   a_r8_fault_holds: assert property (@(posedge clk) disable iff (rst)
      misalign |=> $stable(pc));

   a_r8_fault_scope: assert property (@(posedge clk) disable iff (rst)
      misalign |-> step_en && jmp_reg);

   a_r9_aligned: assert property (@(posedge clk) disable iff (rst)
      pc[ALIGN_BITS-1:0] == '0);
endmodule

bind pc_next_unit pcu_checker #(
   .ADDR_W     (ADDR_W),
   .ALIGN_BITS (ALIGN_BITS)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .step_en  (step_en),
   .br_take  (br_take),
   .jmp_dir  (jmp_dir),
   .jmp_reg  (jmp_reg),
   .reg_val  (reg_val),
   .pc       (pc),
   .misalign (misalign)
);

// File: tb/tb_pc_next_unit.sv
module tb_pc_next_unit;
   logic        clk = 1'b0;
   logic        rst;
   logic        step_en;
   logic        br_take;
   logic [15:0] br_ofs;
   logic        jmp_dir;
   logic [25:0] jmp_field;
   logic        jmp_reg;
   logic [31:0] reg_val;
   logic [31:0] pc;
   logic        misalign;

   int vectors = 0;
   int fails   = 0;
   bit [31:0] mpc;

   localparam bit [31:0] START = 32'h0040_0000;

   pc_next_unit dut (
      .clk(clk), .rst(rst), .step_en(step_en), .br_take(br_take), .br_ofs(br_ofs),
      .jmp_dir(jmp_dir), .jmp_field(jmp_field), .jmp_reg(jmp_reg), .reg_val(reg_val),
      .pc(pc), .misalign(misalign)
   );

   always #4 clk = ~clk;

   task automatic chk(string tag, bit [31:0] act, bit [31:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // one cycle: drive at negedge, check flag, advance model, check pc next negedge
   task automatic step(string tag, bit sen, bit br, bit [15:0] ofs, bit jd,
                       bit [25:0] fld, bit jr, bit [31:0] rv);
      bit        emis;
      bit [31:0] p4;
      step_en = sen; br_take = br; br_ofs = ofs; jmp_dir = jd;
      jmp_field = fld; jmp_reg = jr; reg_val = rv;
      #1;
      emis = sen && jr && (rv[1:0] != 2'b00);
      chk({tag, " flag"}, {31'd0, misalign}, {31'd0, emis});
      p4 = mpc + 32'd4;
      if (sen && !emis) begin
         if (jr)      mpc = rv;
         else if (jd) mpc = {p4[31:28], fld, 2'b00};
         else if (br) mpc = p4 + ({{16{ofs[15]}}, ofs} * 32'd4);
         else         mpc = p4;
      end
      @(posedge clk);
      @(negedge clk);
      chk({tag, " pc"}, pc, mpc);
      chk("R9 low bits", {30'd0, pc[1:0]}, 32'd0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      rst = 1'b1; step_en = 1'b1; br_take = 1'b0; br_ofs = '0; jmp_dir = 1'b1;
      jmp_field = 26'h3FF_FFFF; jmp_reg = 1'b0; reg_val = '0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      mpc = START;
      chk("R1 reset", pc, START);
      chk("R8 flag after reset", {31'd0, misalign}, 32'd0);

      step("R3 seq", 1, 0, 0, 0, 0, 0, 0);
      step("R3 seq", 1, 0, 16'h1234, 0, 26'h15, 0, 32'h3);
      step("R2 hold", 0, 1, 16'h0010, 1, 26'h77, 1, 32'h8000_0000);
      step("R2 hold", 0, 0, 0, 0, 0, 0, 0);
      step("R4 ofs 3", 1, 1, 16'd3, 0, 0, 0, 0);
      step("R4 ofs -1", 1, 1, 16'hFFFF, 0, 0, 0, 0);
      step("R4 ofs max", 1, 1, 16'h7FFF, 0, 0, 0, 0);
      step("R4 ofs min", 1, 1, 16'h8000, 0, 0, 0, 0);
      step("R5 jump", 1, 0, 0, 1, 26'h012_3456, 0, 0);
      step("R6 reg", 1, 0, 0, 0, 0, 1, 32'hF123_4568);
      step("R6 reg edge", 1, 0, 0, 0, 0, 1, 32'h0FFF_FFFC);
      step("R5 region cross", 1, 0, 0, 1, 26'h000_0010, 0, 0);
      chk("R5 region value", pc, 32'h1000_0040);
      step("R7 all three", 1, 1, 16'd5, 1, 26'h2AA, 1, 32'h0000_1000);
      step("R7 jump over branch", 1, 1, 16'd5, 1, 26'h155, 0, 0);
      step("R7 branch", 1, 1, 16'hFFFE, 0, 26'h3FF_FFFF, 0, 32'h1);
      step("R8 bad reg", 1, 1, 16'd7, 1, 26'h9, 1, 32'h0000_2002);
      step("R8 bad reg", 1, 0, 0, 0, 0, 1, 32'hFFFF_FFFF);
      step("R8 ignored no jr", 1, 0, 0, 0, 0, 0, 32'h0000_0001);
      step("R8 ignored idle", 0, 0, 0, 0, 0, 1, 32'h0000_0003);

      for (int i = 0; i < 60; i++) begin
         bit [31:0] r = $urandom;
         if (i % 7 == 0) r[1:0] = 2'b10; else r[1:0] = 2'b00;
         step("R7 mixed", ($urandom % 8) != 0, $urandom % 2, 16'($urandom),
              ($urandom % 3) == 0, 26'($urandom), ($urandom % 4) == 0, r);
      end

      rst = 1'b1; step_en = 1'b1; jmp_reg = 1'b1; reg_val = 32'h0000_8000;
      @(posedge clk);
      @(negedge clk);
      rst = 1'b0; jmp_reg = 1'b0;
      mpc = START;
      chk("R1 reset mid run", pc, START);
      step("R3 after reset", 1, 0, 0, 0, 0, 0, 0);

      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule